// File: doc/BRIEF.md
# Triple Countdown Timer with Interrupt Status and Mask

This peripheral holds three 16-bit countdown timers and a small interrupt unit that collects their zero events together with a raster-line compare strobe. A CPU reaches every register over a byte-wide bus: two bytes per timer, one status byte and one mask byte. The interrupt request output goes high while any latched status bit is also enabled in the mask.

A timer loses one count on each `tick` pulse while it is running. A tick that finds the counter already at zero raises that timer's event and loads the next value into the counter. The first timer reloads the 16-bit value most recently written to it. The other two wrap to 0xFFFF, so software must rewrite them after every event to get a custom period. Writing a timer's low byte halts it. The following high-byte write loads the whole 16-bit value and starts the timer again. Status bits latch whether or not their source is enabled, and software clears them by writing ones.

Top module: `tti_top`

## Requirements
- R1: After reset every timer byte reads 0xFF, the status byte (offset 6) and mask byte (offset 7) read 0x00, `irq` is 0, and no timer counts when ticks arrive.
- R2: A running timer decrements by one on each cycle with `tick` high. A tick that finds the counter at zero raises that timer's zero event.
- R3: Timer 1 (low byte at offset 0, high byte at offset 1) loads the 16-bit value last written to it on its zero event.
- R4: Timer 2 (offsets 2 and 3) and timer 3 (offsets 4 and 5) load 0xFFFF on their zero event.
- R5: A low-byte write stops that timer and holds its count. The next high-byte write loads {high, stored low} and restarts counting.
- R6: A high-byte write with no pending low-byte write keeps the counter's current low byte, replaces the upper byte and starts the timer.
- R7: Status bits latch on their events whatever the mask holds: bit 1 for `raster_hit`, bit 3 for timer 1, bit 4 for timer 2, bit 6 for timer 3. All other status and mask bits read 0, except status bit 7.
- R8: `irq` is 1 exactly when some status bit and the same mask bit are both 1. A status read returns the `irq` level in bit 7.
- R9: Writing the status byte clears each bit written as 1 and leaves bits written as 0 unchanged. `irq` stays high until the bit is cleared.
- R10: When a source event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R11: Reading any register leaves the counters, status and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse for all running timers |
| raster_hit | input | 1 | Raster-line compare strobe |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench uses the default parameters. The byte-wide register map is therefore fixed, and only the first timer is built with the restart-value variant, which gives the free-running wrap of the other two timers a direct contrast. Small start values, including zero, place zero events a few ticks apart. This makes it possible to line up a zero event, a clearing write and a pending low-byte write in chosen cycles, and a long random phase then mixes those cases freely.

// File: rtl/tti_pkg.sv
package tti_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int N_TMR  = 3;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(7);

    localparam int BIT_RASTER = 1;
    localparam int BIT_IRQ    = 7;

    function automatic int tmr_bit(input int idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] flag_mask();
        logic [BYTE_W-1:0] m;
        m = '0;
        m[BIT_RASTER] = 1'b1;
        for (int i = 0; i < N_TMR; i++) m[tmr_bit(i)] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  start;
        logic [BYTE_W-1:0] lo_hold;
        logic              armed;
        logic              run;
    } chan_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] mask;
    } irq_st_t;
endpackage

// File: rtl/tti_chan.sv
module tti_chan
    import tti_pkg::*;
#(
    parameter bit RELOAD_START = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              zero_evt
);
    chan_st_t cur_q, nxt_d;
    logic [CNT_W-1:0]  reload_val;
    logic [BYTE_W-1:0] low_src;

    generate
        if (RELOAD_START) begin : g_restart
            assign reload_val = cur_q.start;
        end else begin : g_wrap
            assign reload_val = '1;
        end
    endgenerate

    always_comb begin
        nxt_d    = cur_q;
        zero_evt = 1'b0;
        low_src  = cur_q.armed ? cur_q.lo_hold : cur_q.cnt[BYTE_W-1:0];
        if (wr_lo) begin
            nxt_d.lo_hold = wdata;
            nxt_d.armed   = 1'b1;
            nxt_d.run     = 1'b0;
        end else if (wr_hi) begin
            nxt_d.cnt   = {wdata, low_src};
            nxt_d.start = {wdata, low_src};
            nxt_d.armed = 1'b0;
            nxt_d.run   = 1'b1;
        end else if (cur_q.run && tick) begin
            if (cur_q.cnt == '0) begin
                zero_evt  = 1'b1;
                nxt_d.cnt = reload_val;
            end else begin
                nxt_d.cnt = cur_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.cnt     <= '1;
            cur_q.start   <= '1;
            cur_q.lo_hold <= '0;
            cur_q.armed   <= 1'b0;
            cur_q.run     <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign count = cur_q.cnt;

    p_lo_write_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !cur_q.run);
    p_stopped_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.run && !wr_hi) |=> $stable(cur_q.cnt));
    p_hi_write_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> cur_q.run);
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.run && tick && !wr_lo && !wr_hi && cur_q.cnt != '0)
        |=> cur_q.cnt == $past(cur_q.cnt) - 1'b1);

    generate
        if (RELOAD_START) begin : g_chk_restart
            p_restart_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
                zero_evt |=> cur_q.cnt == $past(cur_q.start));
        end else begin : g_chk_wrap
            p_wrap_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
                zero_evt |=> cur_q.cnt == '1);
        end
    endgenerate
endmodule

// File: rtl/tti_irq.sv
module tti_irq
    import tti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] src_evt,
    input  logic              wr_stat,
    input  logic              wr_mask,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] stat,
    output logic [BYTE_W-1:0] mask,
    output logic              irq
);
    localparam logic [BYTE_W-1:0] VALID = flag_mask();

    irq_st_t cur_q, nxt_d;
    logic [BYTE_W-1:0] clr;

    always_comb begin
        nxt_d      = cur_q;
        clr        = wr_stat ? wdata : '0;
        nxt_d.stat = ((cur_q.stat & ~clr) | src_evt) & VALID;
        if (wr_mask) nxt_d.mask = wdata & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stat = cur_q.stat;
    assign mask = cur_q.mask;
    assign irq  = |(cur_q.stat & cur_q.mask);

    p_sticky_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (cur_q.stat & $past(cur_q.stat)) == $past(cur_q.stat));
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (src_evt & wdata) == '0) |=> (cur_q.stat & $past(wdata)) == '0);
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> (cur_q.stat & $past(src_evt & VALID)) == $past(src_evt & VALID));
    p_enabled_event_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_evt & cur_q.mask & VALID) != '0 && !wr_mask) |=> irq);
endmodule

// File: rtl/tti_top.sv
module tti_top
    import tti_pkg::*;
#(
    parameter logic [N_TMR-1:0] RELOAD_SEL = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              raster_hit,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  cnt_w [N_TMR];
    logic [N_TMR-1:0]  zero_w;
    logic [BYTE_W-1:0] src_evt;
    logic [BYTE_W-1:0] stat_w, mask_w;

    generate
        for (genvar g = 0; g < N_TMR; g++) begin : g_chan
            logic wr_lo_g, wr_hi_g;
            assign wr_lo_g = bus_wr && (bus_addr == ADDR_W'(2 * g));
            assign wr_hi_g = bus_wr && (bus_addr == ADDR_W'(2 * g + 1));
            tti_chan #(.RELOAD_START(RELOAD_SEL[g])) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .wr_lo    (wr_lo_g),
                .wr_hi    (wr_hi_g),
                .wdata    (bus_wdata),
                .count    (cnt_w[g]),
                .zero_evt (zero_w[g])
            );
        end
    endgenerate

    always_comb begin
        src_evt = '0;
        src_evt[BIT_RASTER] = raster_hit;
        for (int i = 0; i < N_TMR; i++) src_evt[tmr_bit(i)] = zero_w[i];
    end

    tti_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .wr_stat (bus_wr && bus_addr == A_STAT),
        .wr_mask (bus_wr && bus_addr == A_MASK),
        .wdata   (bus_wdata),
        .stat    (stat_w),
        .mask    (mask_w),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (bus_addr == ADDR_W'(2 * i))     bus_rdata = cnt_w[i][BYTE_W-1:0];
            if (bus_addr == ADDR_W'(2 * i + 1)) bus_rdata = cnt_w[i][CNT_W-1:BYTE_W];
        end
        if (bus_addr == A_STAT) begin
            bus_rdata          = stat_w;
            bus_rdata[BIT_IRQ] = irq;
        end
        if (bus_addr == A_MASK) bus_rdata = mask_w;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);
endmodule

// File: tb/tb_tti_top.sv
module tb_tti_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       raster_hit = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cnt [3];
    int m_start [3];
    int m_lo [3];
    bit m_armed [3];
    bit m_run [3];
    int m_stat;
    int m_mask;

    tti_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raster_hit(raster_hit),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int flag_of(int i);
        return (i == 0) ? 3 : (i == 1) ? 4 : 6;
    endfunction

    function automatic bit m_irq();
        return (m_stat & m_mask) != 0;
    endfunction

    function automatic int m_read(int a);
        if (a < 6) return (a % 2 == 0) ? (m_cnt[a / 2] & 255) : ((m_cnt[a / 2] >> 8) & 255);
        if (a == 6) return (m_stat & 127) | (m_irq() ? 128 : 0);
        return m_mask;
    endfunction

    // Reference model, updated on each rising edge from the inputs held there
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 65535; m_start[i] = 65535; m_lo[i] = 0;
                m_armed[i] = 0; m_run[i] = 0;
            end
            m_stat = 0; m_mask = 0;
        end else begin
            int ev;
            ev = 0;
            for (int i = 0; i < 3; i++) begin
                if (bus_wr && bus_addr == 3'(2 * i)) begin
                    m_lo[i] = bus_wdata; m_armed[i] = 1; m_run[i] = 0;
                end else if (bus_wr && bus_addr == 3'(2 * i + 1)) begin
                    int lo;
                    lo = m_armed[i] ? m_lo[i] : (m_cnt[i] & 255);
                    m_cnt[i] = bus_wdata * 256 + lo;
                    m_start[i] = m_cnt[i];
                    m_armed[i] = 0; m_run[i] = 1;
                end else if (m_run[i] && tick) begin
                    if (m_cnt[i] == 0) begin
                        ev = ev | (1 << flag_of(i));
                        m_cnt[i] = (i == 0) ? m_start[i] : 65535;
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end
            end
            if (raster_hit) ev = ev | 2;
            if (bus_wr && bus_addr == 3'd6) m_stat = m_stat & ~int'(bus_wdata);
            m_stat = (m_stat | ev) & 8'h5A;
            if (bus_wr && bus_addr == 3'd7) m_mask = bus_wdata & 8'h5A;
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (bus_rdata !== 8'(m_read(bus_addr))) begin
                errors++;
                $display("FAIL %s addr %0d: rdata actual %02h expected %02h",
                         (bus_addr < 6) ? "R11" : (bus_addr == 6) ? "R7" : "R8",
                         bus_addr, bus_rdata, m_read(bus_addr));
            end
            checks++;
            if (irq !== m_irq()) begin
                errors++;
                $display("FAIL R8 irq actual %0b expected %0b", irq, m_irq());
            end
        end
    end

    task automatic cyc(input bit w, input int a, input int d, input bit t, input bit r);
        @(posedge clk);
        #(CLK_PERIOD / 4);
        bus_wr = w; bus_addr = 3'(a); bus_wdata = 8'(d); tick = t; raster_hit = r;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1, a, d, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0);
    endtask

    task automatic rd(input int a, input int exp, input string req);
        cyc(0, a, 0, 0, 0);
        @(negedge clk);
        #1;
        checks++;
        if (bus_rdata !== 8'(exp)) begin
            errors++;
            $display("FAIL %s read addr %0d actual %02h expected %02h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string req);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 4);
        rst_n = 1'b1;

        // R1: reset values and stopped timers
        for (int a = 0; a < 6; a++) rd(a, 8'hFF, "R1");
        rd(6, 0, "R1");
        rd(7, 0, "R1");
        chk_irq(0, "R1");
        ticks(5);
        rd(0, 8'hFF, "R1");
        rd(5, 8'hFF, "R1");

        // R2/R3: timer 1 start 3, event on the fourth tick, restart at 3
        wr(0, 8'h03); wr(1, 8'h00);
        rd(0, 8'h03, "R5");
        ticks(3);
        rd(0, 8'h00, "R2");
        rd(6, 8'h00, "R2");
        ticks(1);
        rd(6, 8'h08, "R7");
        chk_irq(0, "R7");
        rd(0, 8'h03, "R3");
        rd(1, 8'h00, "R3");

        // R8: enabling the latched flag raises irq
        wr(7, 8'h08);
        rd(6, 8'h88, "R8");
        rd(7, 8'h08, "R8");
        chk_irq(1, "R8");

        // R9: zero bits do not clear, one bits do
        wr(6, 8'h00);
        rd(6, 8'h88, "R9");
        wr(6, 8'h08);
        rd(6, 8'h00, "R9");
        chk_irq(0, "R9");

        // R4: timer 2 wraps to 0xFFFF
        wr(2, 8'h01); wr(3, 8'h00);
        ticks(2);
        rd(2, 8'hFF, "R4");
        rd(3, 8'hFF, "R4");
        rd(6, 8'h10, "R7");
        ticks(1);
        rd(2, 8'hFE, "R4");

        // R4: timer 3 from zero wraps on next tick; timer 1 also fires
        wr(4, 8'h00); wr(5, 8'h00);
        ticks(1);
        rd(4, 8'hFF, "R4");
        rd(5, 8'hFF, "R4");
        rd(6, 8'hD8, "R7");

        // R6: high write alone keeps the low byte and keeps counting
        ticks(1);
        wr(5, 8'h12);
        rd(5, 8'h12, "R6");
        rd(4, 8'hFE, "R6");
        ticks(1);
        rd(4, 8'hFD, "R6");

        // R5: low write halts timer 2 until the high write
        wr(6, 8'hFF);
        rd(2, 8'hFB, "R5");
        wr(2, 8'h40);
        ticks(3);
        rd(2, 8'hFB, "R5");
        rd(3, 8'hFF, "R5");
        wr(3, 8'h00);
        rd(2, 8'h40, "R5");
        rd(3, 8'h00, "R5");

        // R10: event and clear on the same bit in one cycle
        wr(0, 8'h00); wr(1, 8'h00);
        wr(6, 8'hFF);
        rd(6, 8'h00, "R9");
        cyc(1, 6, 8'h08, 1, 0);
        rd(6, 8'h88, "R10");

        // R7/R8: raster source
        wr(6, 8'hFF);
        cyc(0, 0, 0, 0, 1);
        rd(6, 8'h02, "R7");
        wr(7, 8'h02);
        rd(6, 8'h82, "R8");
        chk_irq(1, "R8");
        wr(6, 8'h02);
        rd(6, 8'h00, "R9");

        // R11: reads of every offset while counting, checked against the model
        for (int i = 0; i < 40; i++) cyc(0, i % 8, 0, 1, 0);

        // Mixed random phase, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 12, $urandom_range(0, 7), $urandom_range(0, 3) == 0 ? 0 : $urandom_range(0, 255),
                $urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0);
        end

        cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule